// File: doc/BRIEF.md
# Byte-Port Sample Buffer with Fill Thresholds

This block buffers 16-bit converter samples on their way to a host that can only move one byte per access. The conversion side pushes a whole sample in one cycle. The host drains the buffer through a single byte-wide register. Each sample takes two reads of that register: the low byte comes first and the high byte second. The second read removes the sample.

The same register is also written. After a buffer flush, the host sends a short sequence of byte writes. The first pair of bytes is a near-empty threshold, which this block consumes and then discards. The second pair is the near-full threshold, sent low byte first. That threshold counts free bytes left in the buffer, not stored bytes. The block drives level flags and two sticky events to a separate status block, which acknowledges the events with a clear pulse.

Top module: `byte_sample_fifo`

## Requirements
- R1: After hard reset, isEmpty is 1, isFull, isNearFull, thrEvent and dataLost are 0, hostRdData is 0, and the near-full threshold is 0.
- R2: Samples leave in the order they were pushed. Each sample needs two hostRd pulses. The first read returns bits 7:0 and the second returns bits 15:8 and removes the sample. Each read result appears on hostRdData one cycle after its pulse.
- R3: A hostRd while the buffer is empty returns 0 on hostRdData and does not advance the byte pointer. The next sample pushed is then read starting from its low byte.
- R4: A flushCmd pulse empties the buffer, returns the byte pointer to the low byte and restarts the threshold write sequence. In the same cycle, a push or a read is ignored.
- R5: After a flush, the 1st and 2nd host writes have no effect. The 3rd write is the low byte and the 4th write the high byte of the near-full threshold, which takes effect at the 4th write. Later writes are ignored until the next flush.
- R6: isNearFull is 1 exactly when the free byte count, 2 x (2048 - stored samples), is less than or equal to the near-full threshold.
- R7: isFull is 1 when 2048 samples are stored. A push while full is dropped and sets dataLost. dataLost stays set until evtClear; if a drop and evtClear arrive in the same cycle, the drop wins.
- R8: thrEvent is set one cycle after the near-full condition goes from false to true, and stays set until evtClear. A clear while the condition stays true does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous hard reset |
| pushValid | input | 1 | Converter pushes pushData this cycle |
| pushData | input | 16 | Converted sample |
| hostRd | input | 1 | Host byte read of the buffer register |
| hostWr | input | 1 | Host byte write of the buffer register |
| hostWrData | input | 8 | Byte written by the host |
| hostRdData | output | 8 | Byte returned by the most recent read |
| flushCmd | input | 1 | Buffer reset command pulse |
| evtClear | input | 1 | Status block acknowledges the sticky events |
| isEmpty | output | 1 | No sample stored |
| isNearFull | output | 1 | Free bytes at or below the threshold |
| isFull | output | 1 | All 2048 sample slots in use |
| thrEvent | output | 1 | Sticky near-full crossing event |
| dataLost | output | 1 | Sticky dropped-push event |

## Verification
The main path is tried with a short burst of distinct samples, and with an empty read followed by a late push, which shows whether the byte pointer moves when nothing is read. It is also tried with a flush in the middle of a sample, which shows whether the pointer returns to the low byte. A threshold of 4090 free bytes is loaded behind two dummy bytes, which separates a correct write sequence from one that takes the first pair. A complete fill of 2048 samples followed by an extra push shows that the buffer drops at capacity rather than wrapping. The full drain that follows checks that the order held and that the extra sample never entered.

// File: rtl/bytefifo_pkg.sv
package bytefifo_pkg;
  // strobes sent from the host sequencer to the storage datapath
  typedef struct packed {
    logic flush;  // empty the buffer
    logic push;   // accept the converter sample
    logic drop;   // converter sample refused because full
    logic pop;    // retire the head sample
    logic rdEn;   // capture a byte for the host
    logic rdHi;   // byte select: 1 = upper half of head
  } fifo_strobe_t;
endpackage

// File: rtl/fifo_host_ctrl.sv
module fifo_host_ctrl
  import bytefifo_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pushValid,
  input  logic                hostRd,
  input  logic                hostWr,
  input  logic [BYTE_W-1:0]   hostWrData,
  input  logic                flushCmd,
  input  logic                isEmpty,
  input  logic                isFull,
  output fifo_strobe_t        strobe,
  output logic [2*BYTE_W-1:0] nearFullThr
);
  localparam logic [2:0] PH_THR_LO = 3'd2;
  localparam logic [2:0] PH_THR_HI = 3'd3;
  localparam logic [2:0] PH_DONE   = 3'd4;

  logic              bytePtr;
  logic [2:0]        wrPhase;
  logic [BYTE_W-1:0] thrLowStage;

  always_comb begin
    strobe.flush = flushCmd;
    strobe.push  = pushValid && !isFull && !flushCmd;
    strobe.drop  = pushValid && isFull && !flushCmd;
    strobe.rdEn  = hostRd && !flushCmd;
    strobe.rdHi  = bytePtr;
    strobe.pop   = hostRd && !flushCmd && !isEmpty && bytePtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bytePtr     <= 1'b0;
      wrPhase     <= 3'd0;
      thrLowStage <= '0;
      nearFullThr <= '0;
    end else if (flushCmd) begin
      bytePtr <= 1'b0;
      wrPhase <= 3'd0;
    end else begin
      if (hostRd && !isEmpty) bytePtr <= ~bytePtr;
      if (hostWr && wrPhase != PH_DONE) begin
        wrPhase <= wrPhase + 3'd1;
        if (wrPhase == PH_THR_LO) thrLowStage <= hostWrData;
        if (wrPhase == PH_THR_HI) nearFullThr <= {hostWrData, thrLowStage};
      end
    end
  end
endmodule

// File: rtl/fifo_store.sv
module fifo_store
  import bytefifo_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  fifo_strobe_t        strobe,
  input  logic [2*BYTE_W-1:0] pushData,
  input  logic [2*BYTE_W-1:0] nearFullThr,
  input  logic                evtClear,
  output logic [BYTE_W-1:0]   rdByte,
  output logic                isEmpty,
  output logic                isNearFull,
  output logic                isFull,
  output logic                thrEvent,
  output logic                dataLost
);
  localparam int SW = 2 * BYTE_W;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [SW-1:0] mem [DEPTH];
  logic [AW-1:0] wrIdx, rdIdx;
  logic [CW-1:0] count;
  logic [CW:0]   freeBytes;
  logic [SW-1:0] headWord;
  logic          nearCond, condPrev;

  assign headWord   = mem[rdIdx];
  assign freeBytes  = {CW'(DEPTH) - count, 1'b0};
  assign nearCond   = (32'(freeBytes) <= 32'(nearFullThr));
  assign isEmpty    = (count == '0);
  assign isFull     = (count == CW'(DEPTH));
  assign isNearFull = nearCond;

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrIdx] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx  <= '0;
      rdIdx  <= '0;
      count  <= '0;
      rdByte <= '0;
    end else if (strobe.flush) begin
      wrIdx <= '0;
      rdIdx <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrIdx <= wrIdx + AW'(1);
      if (strobe.pop)  rdIdx <= rdIdx + AW'(1);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      if (strobe.rdEn) begin
        if (isEmpty)          rdByte <= '0;
        else if (strobe.rdHi) rdByte <= headWord[SW-1:BYTE_W];
        else                  rdByte <= headWord[BYTE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condPrev <= 1'b0;
      thrEvent <= 1'b0;
      dataLost <= 1'b0;
    end else begin
      condPrev <= nearCond;
      if (nearCond && !condPrev) thrEvent <= 1'b1;
      else if (evtClear)         thrEvent <= 1'b0;
      if (strobe.drop)           dataLost <= 1'b1;
      else if (evtClear)         dataLost <= 1'b0;
    end
  end
endmodule

// File: rtl/byte_sample_fifo.sv
module byte_sample_fifo
  import bytefifo_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pushValid,
  input  logic [2*BYTE_W-1:0] pushData,
  input  logic                hostRd,
  input  logic                hostWr,
  input  logic [BYTE_W-1:0]   hostWrData,
  output logic [BYTE_W-1:0]   hostRdData,
  input  logic                flushCmd,
  input  logic                evtClear,
  output logic                isEmpty,
  output logic                isNearFull,
  output logic                isFull,
  output logic                thrEvent,
  output logic                dataLost
);
  fifo_strobe_t        strobe;
  logic [2*BYTE_W-1:0] nearFullThr;

  fifo_host_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .hostRd(hostRd),
    .hostWr(hostWr), .hostWrData(hostWrData), .flushCmd(flushCmd),
    .isEmpty(isEmpty), .isFull(isFull), .strobe(strobe),
    .nearFullThr(nearFullThr)
  );

  fifo_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushData(pushData),
    .nearFullThr(nearFullThr), .evtClear(evtClear), .rdByte(hostRdData),
    .isEmpty(isEmpty), .isNearFull(isNearFull), .isFull(isFull),
    .thrEvent(thrEvent), .dataLost(dataLost)
  );
endmodule

// File: rtl/byte_sample_fifo_checker.sv
module byte_sample_fifo_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushValid,
  input logic              hostRd,
  input logic              flushCmd,
  input logic              evtClear,
  input logic [BYTE_W-1:0] hostRdData,
  input logic              isEmpty,
  input logic              isNearFull,
  input logic              isFull,
  input logic              thrEvent,
  input logic              dataLost
);
  a_r3_empty_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    hostRd && isEmpty && !flushCmd |=> hostRdData == '0);

  a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flushCmd |=> isEmpty && !isFull);

  a_r6_full_is_nearfull: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> isNearFull && !isEmpty);

  a_r7_drop_sets_lost: assert property (@(posedge clk) disable iff (!rstN)
    pushValid && isFull && !flushCmd |=> dataLost);

  a_r7_lost_sticky: assert property (@(posedge clk) disable iff (!rstN)
    dataLost && !evtClear |=> dataLost);

  a_r8_event_sticky: assert property (@(posedge clk) disable iff (!rstN)
    thrEvent && !evtClear |=> thrEvent);

  a_r8_event_needs_level: assert property (@(posedge clk) disable iff (!rstN)
    $rose(thrEvent) |-> $past(isNearFull));
endmodule

bind byte_sample_fifo byte_sample_fifo_checker #(.BYTE_W(BYTE_W)) u_checker (
  .clk(clk), .rstN(rstN), .pushValid(pushValid), .hostRd(hostRd),
  .flushCmd(flushCmd), .evtClear(evtClear), .hostRdData(hostRdData),
  .isEmpty(isEmpty), .isNearFull(isNearFull), .isFull(isFull),
  .thrEvent(thrEvent), .dataLost(dataLost)
);

// File: tb/byte_sample_fifo_bench.sv
module byte_sample_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 2048;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0, hostRd = 1'b0, hostWr = 1'b0;
  logic flushCmd = 1'b0, evtClear = 1'b0;
  logic [15:0] pushData = '0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic isEmpty, isNearFull, isFull, thrEvent, dataLost;

  int nTests = 0;
  int nFail = 0;
  logic [15:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_sample_fifo u_byte_sample_fifo (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .hostRd(hostRd), .hostWr(hostWr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .flushCmd(flushCmd), .evtClear(evtClear),
    .isEmpty(isEmpty), .isNearFull(isNearFull), .isFull(isFull),
    .thrEvent(thrEvent), .dataLost(dataLost)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // driver: pushes and records what the buffer should hold
  task automatic pushSample(input logic [15:0] d);
    @(negedge clk);
    pushValid = 1'b1;
    pushData  = d;
    if (expQ.size() < CAP) expQ.push_back(d);
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  task automatic hostReadByte(output logic [7:0] b);
    @(negedge clk);
    hostRd = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    b = hostRdData;
  endtask

  task automatic hostWriteByte(input logic [7:0] b);
    @(negedge clk);
    hostWr = 1'b1;
    hostWrData = b;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic pulseFlush();
    @(negedge clk);
    flushCmd = 1'b1;
    @(negedge clk);
    flushCmd = 1'b0;
    expQ.delete();
  endtask

  task automatic pulseClear();
    @(negedge clk);
    evtClear = 1'b1;
    @(negedge clk);
    evtClear = 1'b0;
  endtask

  // monitor: reads one sample and compares against the scoreboard head
  task automatic readSample(input string tag);
    logic [7:0] lo, hi;
    logic [15:0] exp;
    if (expQ.size() == 0) begin
      check({tag, " scoreboard empty"}, 1, 0);
      return;
    end
    exp = expQ.pop_front();
    hostReadByte(lo);
    hostReadByte(hi);
    check(tag, {hi, lo}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 empty", isEmpty, 1);
    check("R1 full", isFull, 0);
    check("R1 nearfull", isNearFull, 0);
    check("R1 thrEvent", thrEvent, 0);
    check("R1 dataLost", dataLost, 0);
    check("R1 rdData", hostRdData, 0);

    // R2 ordered burst, byte order low then high
    pushSample(16'h1234);
    pushSample(16'hA55A);
    pushSample(16'h00FF);
    check("R2 not empty", isEmpty, 0);
    readSample("R2 sample0");
    readSample("R2 sample1");
    readSample("R2 sample2");
    check("R2 drained", isEmpty, 1);

    // R3 empty read returns zero, pointer held
    pushSample(16'h0101);
    readSample("R3 prime");
    hostReadByte(b);
    check("R3 empty read zero", b, 0);
    pushSample(16'h5A6B);
    hostReadByte(b);
    check("R3 low byte after empty read", b, 8'h6B);
    hostReadByte(b);
    check("R3 high byte after empty read", b, 8'h5A);
    void'(expQ.pop_front());

    // R4 flush mid-sample resets byte pointer
    pushSample(16'h1234);
    hostReadByte(b);
    check("R4 first low byte", b, 8'h34);
    pulseFlush();
    check("R4 flushed empty", isEmpty, 1);
    pushSample(16'hABCD);
    readSample("R4 new sample after flush");

    // R4 flush wins over same-cycle push
    @(negedge clk);
    flushCmd = 1'b1; pushValid = 1'b1; pushData = 16'hBEEF;
    @(negedge clk);
    flushCmd = 1'b0; pushValid = 1'b0;
    expQ.delete();
    check("R4 push during flush ignored", isEmpty, 1);

    // R5 threshold sequence: two dummy bytes, then 4090 = 0x0FFA
    hostWriteByte(8'hFF);
    hostWriteByte(8'hFF);
    hostWriteByte(8'hFA);
    check("R5 threshold not yet committed", isNearFull, 0);
    hostWriteByte(8'h0F);
    hostWriteByte(8'h00);  // ignored, sequence done
    pushSample(16'h0001);
    pushSample(16'h0002);
    check("R6 free 4092 above threshold", isNearFull, 0);
    check("R8 no event yet", thrEvent, 0);
    pushSample(16'h0003);
    check("R6 free 4090 at threshold", isNearFull, 1);
    check("R8 event lags one cycle", thrEvent, 0);
    @(negedge clk);
    check("R8 event set", thrEvent, 1);
    check("R5 late write ignored", isNearFull, 1);
    pulseClear();
    check("R8 event cleared", thrEvent, 0);
    @(negedge clk);
    check("R8 no refire while level holds", thrEvent, 0);
    readSample("R2 thr s0");
    check("R6 below threshold after pop", isNearFull, 0);
    readSample("R2 thr s1");
    readSample("R2 thr s2");

    // R7 fill to capacity, overflow drop, drain order
    pulseFlush();
    pulseClear();
    for (int i = 0; i < CAP - 1; i++) pushSample(16'(i * 3 + 1));
    check("R7 not full at 2047", isFull, 0);
    pushSample(16'hC0DE);
    check("R7 full at 2048", isFull, 1);
    check("R7 no loss yet", dataLost, 0);
    pushSample(16'hDEAD);
    check("R7 drop sets dataLost", dataLost, 1);
    check("R7 still full", isFull, 1);
    for (int i = 0; i < CAP; i++) readSample("R7 drain order");
    check("R7 empty after drain", isEmpty, 1);
    check("R7 dataLost sticky", dataLost, 1);
    pulseClear();
    check("R7 dataLost cleared", dataLost, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule